// File: doc/BRIEF.md
# Page-Mode Memory Read Sequencer

This block sits on the host side of an asynchronous parallel read-only memory that can deliver data faster when successive reads stay inside one page. A client presents a read request with a byte address and a flag that selects word or byte access. The sequencer drives the memory address, the byte-select line, the width-select line and the active-low chip-enable and output-enable lines. It counts clock cycles until the data on the memory bus can be trusted, captures it, and returns it with a one-cycle valid strobe.

A page covers 8 words, or 16 bytes when byte access is selected. The block remembers which page is open and keeps chip-enable low between requests. A request that falls in the open page, uses the same width and arrives while chip-enable is still low waits only the short in-page count. Any other request waits the full random-access count. If no request comes within an idle count, both enables are released so the memory can drop into standby. The sequencer then stays busy for a float count, so that another device may not drive the bus until this memory's outputs have gone high-impedance.

Each request walks through the states STANDBY, ACCESS and OPEN, and the release path passes through FLOAT. The transitions are: STANDBY to ACCESS on an accepted request (a page miss). OPEN to ACCESS on an accepted request (a hit or a miss). ACCESS to OPEN when the wait count expires, which is also when data is captured. OPEN to FLOAT when the idle count expires. FLOAT to STANDBY when the float count expires.

Top module: `pgrd_seq`

## Requirements
- R1: After reset, mem_ce_n and mem_oe_n are 1, busy is 0 and rsp_valid is 0.
- R2: A request accepted in standby drives mem_ce_n and mem_oe_n low on the accepting clock edge. rsp_valid rises T_ACC clock edges after that edge, carrying the word stored at word address req_addr[AW:1]. In word mode mem_wide is 1 and mem_bsel is 0.
- R3: A word request whose page tag req_addr[AW:PG+1] matches the open page, while chip-enable is still low, is returned after T_PAGE edges.
- R4: A request to a different page while chip-enable is low waits T_ACC edges, and mem_ce_n stays low throughout.
- R5: In byte mode (req_byte=1), mem_wide is 0 and mem_bsel equals req_addr[0]. rsp_data holds the selected byte in bits 7:0, with bits DW-1:8 zero. A byte request inside the same 16-byte page is a hit, including in-page offset 15. Offset 16 starts a new page and is a miss.
- R6: A request that changes the width mode is a miss and waits T_ACC edges, even when the page tag matches.
- R7: While a read is in progress, mem_ce_n stays low and mem_addr and mem_bsel hold steady. rsp_valid is high for exactly one cycle.
- R8: If no request is accepted for IDLE_MAX edges after the edge on which rsp_valid rises, mem_ce_n and mem_oe_n both go high on that edge.
- R9: After the enables are released, busy stays high for T_FLOAT cycles and mem_ce_n stays high. A request presented during that time gets no response. The next accepted request is a miss, even when it falls in the old page.
- R10: A request presented while busy is ignored: it causes no response and does not change mem_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present; taken only when busy is 0 |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | AW+1 | Byte address; bit 0 selects the byte in byte mode |
| busy | output | 1 | Request not accepted in this cycle |
| rsp_valid | output | 1 | One-cycle strobe marking rsp_data valid |
| rsp_data | output | DW | Captured word, or zero-extended byte |
| mem_addr | output | AW | Word address to the memory |
| mem_bsel | output | 1 | Byte-select address line (byte mode only) |
| mem_wide | output | 1 | Width select: 1 = word, 0 = byte |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_data | input | DW | Data bus from the memory |

## Verification
The assertions are checked on every cycle. They cover the following:
- the response strobe lasts one cycle;
- the address and byte select stay steady while busy;
- chip-enable cannot rise in the middle of a read, and cannot fall again during the float window;
- a release of the enables always brings busy with it;
- data is captured only with both enables low.

Only the bench scenarios can show the exact latency counts for hits and misses, the page boundary at byte offset 16, a mode change counting as a miss, the idle release count, and that requests arriving during a read or during the float window are dropped.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY,
        ST_ACCESS,
        ST_OPEN,
        ST_FLOAT
    } pgrd_state_e;
endpackage

// File: rtl/pgrd_timer.sv
// Loadable down-counter; zero flag reflects the value before the next edge.
module pgrd_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgrd_pagetrack.sv
// Remembers the open page tag and width mode; reports a hit for a new request.
module pgrd_pagetrack #(
    parameter int TW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store,
    input  logic          clear,
    input  logic [TW-1:0] tag_in,
    input  logic          byte_in,
    output logic          hit
);
    logic [TW-1:0] tag_q;
    logic          byte_q;
    logic          open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            byte_q <= 1'b0;
            open_q <= 1'b0;
        end else if (store) begin
            tag_q  <= tag_in;
            byte_q <= byte_in;
            open_q <= 1'b1;
        end else if (clear) begin
            open_q <= 1'b0;
        end
    end

    assign hit = open_q && (tag_q == tag_in) && (byte_q == byte_in);
endmodule

// File: rtl/pgrd_lane.sv
// Selects the returned lane: full word, or the low byte zero-extended.
module pgrd_lane #(
    parameter int DW = 16
) (
    input  logic          byte_mode,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int BW = DW / 2;

    always_comb begin
        if (byte_mode) begin
            dout = {{(DW-BW){1'b0}}, din[BW-1:0]};
        end else begin
            dout = din;
        end
    end
endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq #(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int PG       = 3,
    parameter int T_ACC    = 9,
    parameter int T_PAGE   = 5,
    parameter int T_FLOAT  = 4,
    parameter int IDLE_MAX = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_byte,
    input  logic [AW:0]   req_addr,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_bsel,
    output logic          mem_wide,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    input  logic [DW-1:0] mem_data
);
    import pgrd_pkg::*;

    localparam int TW   = AW - PG;
    localparam int TM1  = (T_ACC > T_FLOAT) ? T_ACC : T_FLOAT;
    localparam int TMAX = (TM1 > IDLE_MAX) ? TM1 : IDLE_MAX;
    localparam int CW   = $clog2(TMAX + 1);

    pgrd_state_e state_q, state_d;

    logic          accept, hit, capture, release_en;
    logic          acc_zero, idle_zero;
    logic          acc_load;
    logic [CW-1:0] acc_val;
    logic          byte_q;
    logic [DW-1:0] lane_data;

    assign busy       = (state_q == ST_ACCESS) || (state_q == ST_FLOAT);
    assign accept     = req_valid && !busy;
    assign capture    = (state_q == ST_ACCESS) && acc_zero;
    assign release_en = (state_q == ST_OPEN) && !accept && idle_zero;

    assign acc_load = accept || release_en;
    always_comb begin
        if (accept) begin
            acc_val = hit ? CW'(T_PAGE - 1) : CW'(T_ACC - 1);
        end else begin
            acc_val = CW'(T_FLOAT - 1);
        end
    end

    pgrd_timer #(.CW(CW)) u_acc_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_load),
        .load_val (acc_val),
        .dec      (busy),
        .zero     (acc_zero)
    );

    pgrd_timer #(.CW(CW)) u_idle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (capture),
        .load_val (CW'(IDLE_MAX - 1)),
        .dec      ((state_q == ST_OPEN) && !accept),
        .zero     (idle_zero)
    );

    pgrd_pagetrack #(.TW(TW)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .store   (accept),
        .clear   (release_en),
        .tag_in  (req_addr[AW:PG+1]),
        .byte_in (req_byte),
        .hit     (hit)
    );

    pgrd_lane #(.DW(DW)) u_lane (
        .byte_mode (byte_q),
        .din       (mem_data),
        .dout      (lane_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (accept)     state_d = ST_ACCESS;
            ST_ACCESS:  if (acc_zero)   state_d = ST_OPEN;
            ST_OPEN: begin
                if (accept)             state_d = ST_ACCESS;
                else if (idle_zero)     state_d = ST_FLOAT;
            end
            ST_FLOAT:   if (acc_zero)   state_d = ST_STANDBY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_addr  <= '0;
            mem_bsel  <= 1'b0;
            mem_wide  <= 1'b1;
            byte_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_data <= lane_data;
            end
            if (accept) begin
                mem_ce_n <= 1'b0;
                mem_oe_n <= 1'b0;
                mem_addr <= req_addr[AW:1];
                mem_bsel <= req_byte & req_addr[0];
                mem_wide <= !req_byte;
                byte_q   <= req_byte;
            end else if (release_en) begin
                mem_ce_n <= 1'b1;
                mem_oe_n <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgrd_seq_chk.sv
module pgrd_seq_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_bsel,
    input logic          mem_ce_n,
    input logic          mem_oe_n
);
    // R7: response strobe lasts a single cycle
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7 / R10: address lines hold while a read or float is in progress
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mem_addr) && $stable(mem_bsel)));

    // R7: chip enable cannot rise in the middle of a read
    a_r7_ce_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ce_n) |=> !mem_ce_n);

    // R2: data is only returned with both enables active and not busy
    a_r2_capture_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!mem_ce_n && !mem_oe_n && !busy));

    // R9: chip enable stays released during the float window
    a_r9_float_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_ce_n) |=> mem_ce_n);

    // R9: a release always starts the busy float window
    a_r9_release_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> busy);

    // R8: output enable never stays low without chip enable
    a_r8_oe_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> mem_oe_n);
endmodule

bind pgrd_seq pgrd_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_bsel  (mem_bsel),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/pgrd_seq_tb.sv
`timescale 1ns/1ps
module pgrd_seq_tb;
    localparam int CLK_P    = 10;
    localparam int AW       = 18;
    localparam int DW       = 16;
    localparam int T_ACC    = 9;
    localparam int T_PAGE   = 5;
    localparam int T_FLOAT  = 4;
    localparam int IDLE_MAX = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_byte = 1'b0;
    logic [AW:0]   req_addr = '0;
    logic          busy, rsp_valid, mem_bsel, mem_wide, mem_ce_n, mem_oe_n;
    logic [DW-1:0] rsp_data, mem_data;
    logic [AW-1:0] mem_addr;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pgrd_seq #(
        .AW(AW), .DW(DW), .PG(3), .T_ACC(T_ACC), .T_PAGE(T_PAGE),
        .T_FLOAT(T_FLOAT), .IDLE_MAX(IDLE_MAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_byte(req_byte),
        .req_addr(req_addr), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_bsel(mem_bsel),
        .mem_wide(mem_wide), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_data(mem_data)
    );

    function automatic logic [15:0] word_at(input logic [AW-1:0] w);
        return (w[15:0] * 16'd40503) ^ {14'h2C5, w[17:16]};
    endfunction

    // Memory model: drives a marker pattern unless both enables are low
    always_comb begin
        logic [15:0] v;
        v = word_at(mem_addr);
        if (mem_ce_n || mem_oe_n) mem_data = 16'h5A5A;
        else if (mem_wide)        mem_data = v;
        else if (mem_bsel)        mem_data = {8'h00, v[15:8]};
        else                      mem_data = {8'h00, v[7:0]};
    end

    function automatic logic [15:0] expect_val(input logic [AW:0] ba, input logic bm);
        logic [15:0] v;
        v = word_at(ba[AW:1]);
        if (!bm) return v;
        return ba[0] ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Issue one request at a negedge; returns at the negedge after the strobe cycle
    task automatic do_req(input logic [AW:0] ba, input logic bm, input int lat,
                          input string rq);
        int n;
        bit ce_rose;
        logic [15:0] exp;
        exp = expect_val(ba, bm);
        req_addr = ba; req_byte = bm; req_valid = 1'b1;
        chk(!busy, {rq, " not busy before request"}, busy, 0);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !mem_ce_n && !mem_oe_n, {rq, " enables low and busy"},
            {busy, mem_ce_n, mem_oe_n}, 3'b100);
        chk(mem_addr == ba[AW:1], {rq, " address"}, mem_addr, ba[AW:1]);
        chk(mem_wide == !bm && mem_bsel == (bm & ba[0]), {rq, " R5 width/bsel"},
            {mem_wide, mem_bsel}, {!bm, bm & ba[0]});
        n = 0; ce_rose = 1'b0;
        while (!rsp_valid && n < 64) begin
            @(posedge clk); n++; @(negedge clk);
            if (mem_ce_n) ce_rose = 1'b1;
        end
        chk(n == lat, {rq, " latency"}, n, lat);
        chk(rsp_data == exp, {rq, " data"}, rsp_data, exp);
        chk(!ce_rose, {rq, " R7 ce held low"}, ce_rose, 0);
        @(posedge clk); @(negedge clk);
        chk(!rsp_valid, {rq, " R7 single-cycle strobe"}, rsp_valid, 0);
    endtask

    task automatic t_reset;
        chk(mem_ce_n && mem_oe_n && !busy && !rsp_valid, "R1 reset state",
            {mem_ce_n, mem_oe_n, busy, rsp_valid}, 4'b1100);
    endtask

    task automatic t_word_burst;
        do_req({18'h01230, 1'b0}, 1'b0, T_ACC,  "R2 miss from standby");
        do_req({18'h01235, 1'b0}, 1'b0, T_PAGE, "R3 page hit");
        do_req({18'h01237, 1'b0}, 1'b0, T_PAGE, "R3 page hit last word");
        chk(!mem_ce_n, "R4 ce still low before new page", mem_ce_n, 0);
        do_req({18'h2A5C8, 1'b0}, 1'b0, T_ACC,  "R4 page miss ce low");
    endtask

    task automatic t_byte_mode;
        do_req({18'h2A5C8, 1'b0}, 1'b1, T_ACC,  "R6 mode change miss");
        do_req({18'h2A5CB, 1'b1}, 1'b1, T_PAGE, "R5 byte hit upper byte");
        do_req({18'h2A5CF, 1'b1}, 1'b1, T_PAGE, "R5 byte offset 15 hit");
        do_req({18'h2A5D0, 1'b0}, 1'b1, T_ACC,  "R5 byte offset 16 miss");
    endtask

    task automatic t_busy_ignore;
        int n;
        logic [15:0] exp;
        exp = expect_val({18'h00400, 1'b0}, 1'b0);
        req_addr = {18'h00400, 1'b0}; req_byte = 1'b0; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_addr = {18'h3F001, 1'b0};
        n = 0;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk); n++; @(negedge clk);
            chk(mem_addr == 18'h00400, "R10 address unchanged while busy",
                mem_addr, 18'h00400);
        end
        req_valid = 1'b0;
        while (!rsp_valid && n < 64) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk(n == T_ACC, "R10 latency of first request", n, T_ACC);
        chk(rsp_data == exp, "R10 data of first request", rsp_data, exp);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); @(negedge clk);
            if (rsp_valid) n++;
        end
        chk(n == 0, "R10 no response to ignored request", n, 0);
    endtask

    task automatic t_idle_release;
        int n;
        int k;
        int vcnt;
        do_req({18'h00401, 1'b0}, 1'b0, T_PAGE, "R3 hit before idle");
        n = 1;
        while (!mem_ce_n && n < 64) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk(n == IDLE_MAX, "R8 idle release count", n, IDLE_MAX);
        chk(mem_oe_n, "R8 output enable released", mem_oe_n, 1);
        chk(busy, "R9 busy at release", busy, 1);
        req_addr = {18'h00402, 1'b0}; req_byte = 1'b0; req_valid = 1'b1;
        k = 1; vcnt = 0;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        while (busy && k < 64) begin
            k++;
            if (!mem_ce_n) vcnt++;
            if (rsp_valid) vcnt++;
            @(posedge clk); @(negedge clk);
        end
        chk(k == T_FLOAT, "R9 float window length", k, T_FLOAT);
        chk(vcnt == 0 && mem_ce_n && !rsp_valid, "R9 no activity during float",
            vcnt, 0);
        do_req({18'h00402, 1'b0}, 1'b0, T_ACC, "R9 old page is a miss");
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_burst();
        t_byte_mode();
        t_busy_ignore();
        t_idle_release();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule